// File: doc/BRIEF.md
# Tile Mode Register Bracketing Sequencer

This block sits in front of a command ring and wraps one group of copy or fill command dwords. When either surface of the group uses Y tiling, the engine's tiling control register must hold a non-default setting while the group runs. The engine is meant to look stateless to every other client, so the register is put back to its default inside the same batch. Each change of the register follows a mandatory engine flush packet.

A group begins with a one-cycle `start`. On that cycle the block captures the destination tiling, the source tiling, a source-present flag, the largest size the enclosed commands can reach and the free space left in the ring. It works out the register value. If the value is non-zero, it checks the ring space and may request a ring flush. It then emits a flush packet and a register-load packet. After that it passes the enclosed dwords through until one is marked last. It closes with a second flush packet and a register load that restores the default data bits. If the value is zero, only the enclosed dwords come out.

An implicit ring flush between the two brackets would split the setting from its restore, so one that is requested while a bracketed body is open is flagged.

Top module: `tile_bracket_seq`

## Requirements
- R1: After reset `busy`, `body_open`, `out_valid`, `ring_flush`, `flush_conflict` and `done` are all low.
- R2: Tiling codes are 2'b00 linear, 2'b01 X and 2'b10 Y. The register value has bit 0 set in both halves (bits 0 and 16) when the destination is Y-tiled. It has bit 1 set in both halves (bits 1 and 17) when the source is present and Y-tiled. All other bits are zero.
- R3: When the register value is zero, the output stream is exactly the enclosed dwords. No flush or load packet is emitted and no ring flush is requested.
- R4: When the value is non-zero, the output begins with seven dwords in this order: 32'h1300_0002, 0, 0, 0, 32'h1100_0001, 32'h0002_2200, and then the value.
- R5: For a non-zero value, `ring_flush` pulses once before any output dword when `free_space` < 14 + `max_body`. It stays low when `free_space` is equal to or greater than that sum.
- R6: Enclosed dwords are accepted only while `body_open` is high. They are forwarded in order, one output dword per accepted input, and the dword with `body_last` high ends the body.
- R7: For a non-zero value, the body is followed by 32'h1300_0002, 0, 0, 0, 32'h1100_0001, 32'h0002_2200, and then the value with bits 15:0 cleared, keeping bits 31:16.
- R8: `implicit_flush` high on a cycle while a bracketed body is open gives a one-cycle `flush_conflict` pulse. It has no effect when the body is not bracketed.
- R9: `done` pulses for one cycle after the last dword of the group has appeared, and `busy` then returns low.
- R10: `src_tile` has no effect on the value when `src_present` is low.
- R11: `body_valid` while the block is idle produces no output dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a group; captures the configuration inputs |
| dst_tile | input | 2 | Destination tiling code |
| src_tile | input | 2 | Source tiling code |
| src_present | input | 1 | A source surface takes part in the group |
| max_body | input | SPACE_W | Largest possible enclosed size in dwords |
| free_space | input | SPACE_W | Free ring space in dwords at start |
| body_valid | input | 1 | Enclosed dword present |
| body_data | input | 32 | Enclosed dword |
| body_last | input | 1 | Marks the final enclosed dword |
| implicit_flush | input | 1 | Ring wants to flush on its own |
| busy | output | 1 | A group is in progress |
| body_open | output | 1 | Enclosed dwords are accepted this cycle |
| out_valid | output | 1 | Output dword valid |
| out_data | output | 32 | Output dword toward the ring |
| ring_flush | output | 1 | Pulse: flush the ring before the group |
| flush_conflict | output | 1 | Pulse: implicit flush inside a bracket |
| done | output | 1 | Pulse: group complete |

## Verification
The assertions assume that `start` comes only while `busy` is low and that enclosed dwords arrive only while `body_open` is high. They also assume that the space check is settled before any dword leaves, so a ring flush never coincides with output. The stimulus keeps to these rules. Each group is issued only after the previous `done`, and each body dword is driven only after `body_open` is seen high. The only out-of-protocol stimulus is `body_valid` driven while idle, which exercises the ignore rule at the ports.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_PRO, ST_BODY, ST_EPI, ST_DONE
  } seq_state_e;

  localparam logic [1:0] TILE_LINEAR = 2'b00;
  localparam logic [1:0] TILE_X      = 2'b01;
  localparam logic [1:0] TILE_Y      = 2'b10;

  localparam int FLUSH_LEN   = 4;
  localparam int LOAD_LEN    = 3;
  localparam int PKT_DWORDS  = FLUSH_LEN + LOAD_LEN;
  localparam int BRACKET_OVH = PKT_DWORDS * 2;
endpackage

// File: rtl/tbr_value_calc.sv
module tbr_value_calc #(
  parameter int DST_BIT = 0,
  parameter int SRC_BIT = 1
) (
  input  logic [1:0]  dst_tile,
  input  logic [1:0]  src_tile,
  input  logic        src_present,
  output logic [31:0] set_val,
  output logic [31:0] rest_val,
  output logic        bracket
);
  import tbr_pkg::*;

  logic [15:0] data_bits;

  always_comb begin
    data_bits = '0;
    if (dst_tile == TILE_Y) data_bits[DST_BIT] = 1'b1;
    if (src_present && (src_tile == TILE_Y)) data_bits[SRC_BIT] = 1'b1;
    set_val  = {data_bits, data_bits};
    rest_val = {data_bits, 16'h0000};
    bracket  = |data_bits;
  end
endmodule

// File: rtl/tbr_packet_gen.sv
module tbr_packet_gen #(
  parameter logic [31:0] FLUSH_OPC = 32'h1300_0000,
  parameter logic [31:0] LOAD_OPC  = 32'h1100_0000,
  parameter logic [31:0] CTRL_ADDR = 32'h0002_2200
) (
  input  logic [2:0]  idx,
  input  logic [31:0] value,
  output logic [31:0] dword
);
  import tbr_pkg::*;

  localparam logic [31:0] FLUSH_HDR = FLUSH_OPC | 32'(FLUSH_LEN - 2);
  localparam logic [31:0] LOAD_HDR  = LOAD_OPC  | 32'(LOAD_LEN - 2);

  always_comb begin
    case (idx)
      3'd0:    dword = FLUSH_HDR;
      3'd4:    dword = LOAD_HDR;
      3'd5:    dword = CTRL_ADDR;
      3'd6:    dword = value;
      default: dword = 32'h0;
    endcase
  end
endmodule

// File: rtl/tbr_fsm.sv
module tbr_fsm #(
  parameter int SPACE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         dst_tile,
  input  logic [1:0]         src_tile,
  input  logic               src_present,
  input  logic [SPACE_W-1:0] max_body,
  input  logic [SPACE_W-1:0] free_space,
  input  logic               body_valid,
  input  logic               body_last,
  input  logic               implicit_flush,
  input  logic               bracket,
  output logic [1:0]         cfg_dst,
  output logic [1:0]         cfg_src,
  output logic               cfg_srcp,
  output logic [2:0]         idx,
  output logic               emit_pkt,
  output logic               emit_body,
  output logic               use_restore,
  output logic               busy,
  output logic               body_open,
  output logic               ring_flush,
  output logic               flush_conflict,
  output logic               done
);
  import tbr_pkg::*;

  localparam logic [2:0] LAST_IDX = 3'(PKT_DWORDS - 1);

  seq_state_e         state_q, state_d;
  logic [2:0]         idx_q, idx_d;
  logic [SPACE_W-1:0] max_q, free_q;
  logic               flush_d, conflict_d, done_d;
  logic               cfg_en, idx_en;
  logic [SPACE_W:0]   space_need;
  logic               space_short;

  assign cfg_en      = (state_q == ST_IDLE) && start;
  assign space_need  = (SPACE_W+1)'(BRACKET_OVH) + {1'b0, max_q};
  assign space_short = ({1'b0, free_q} < space_need);

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    emit_pkt   = 1'b0;
    emit_body  = 1'b0;
    flush_d    = 1'b0;
    conflict_d = 1'b0;
    done_d     = 1'b0;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_CHECK;
      ST_CHECK: begin
        idx_d = '0;
        if (bracket) begin
          flush_d = space_short;
          state_d = ST_PRO;
        end else begin
          state_d = ST_BODY;
        end
      end
      ST_PRO: begin
        emit_pkt = 1'b1;
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          state_d = ST_BODY;
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end
      ST_BODY: begin
        emit_body  = body_valid;
        conflict_d = implicit_flush && bracket;
        if (body_valid && body_last) begin
          idx_d   = '0;
          state_d = bracket ? ST_EPI : ST_DONE;
        end
      end
      ST_EPI: begin
        emit_pkt = 1'b1;
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          state_d = ST_DONE;
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end
      ST_DONE: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign idx_en = emit_pkt || (state_q == ST_CHECK) || (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      ring_flush     <= 1'b0;
      flush_conflict <= 1'b0;
      done           <= 1'b0;
    end else begin
      state_q        <= state_d;
      ring_flush     <= flush_d;
      flush_conflict <= conflict_d;
      done           <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_dst  <= TILE_LINEAR;
      cfg_src  <= TILE_LINEAR;
      cfg_srcp <= 1'b0;
      max_q    <= '0;
      free_q   <= '0;
    end else if (cfg_en) begin
      cfg_dst  <= dst_tile;
      cfg_src  <= src_tile;
      cfg_srcp <= src_present;
      max_q    <= max_body;
      free_q   <= free_space;
    end
  end

  assign idx         = idx_q;
  assign use_restore = (state_q == ST_EPI);
  assign busy        = (state_q != ST_IDLE);
  assign body_open   = (state_q == ST_BODY);

  assert_pro_needs_bracket_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRO || state_q == ST_EPI) |-> bracket);

  assert_conflict_from_body_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_conflict |-> $past(state_q == ST_BODY));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flush_from_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_flush |-> state_q == ST_PRO && idx_q == 3'd0);
endmodule

// File: rtl/tile_bracket_seq.sv
module tile_bracket_seq #(
  parameter int          SPACE_W   = 16,
  parameter logic [31:0] FLUSH_OPC = 32'h1300_0000,
  parameter logic [31:0] LOAD_OPC  = 32'h1100_0000,
  parameter logic [31:0] CTRL_ADDR = 32'h0002_2200,
  parameter int          DST_BIT   = 0,
  parameter int          SRC_BIT   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         dst_tile,
  input  logic [1:0]         src_tile,
  input  logic               src_present,
  input  logic [SPACE_W-1:0] max_body,
  input  logic [SPACE_W-1:0] free_space,
  input  logic               body_valid,
  input  logic [31:0]        body_data,
  input  logic               body_last,
  input  logic               implicit_flush,
  output logic               busy,
  output logic               body_open,
  output logic               out_valid,
  output logic [31:0]        out_data,
  output logic               ring_flush,
  output logic               flush_conflict,
  output logic               done
);
  logic [1:0]  cfg_dst, cfg_src;
  logic        cfg_srcp, bracket;
  logic [31:0] set_val, rest_val, pkt_value, pkt_dword;
  logic [2:0]  idx;
  logic        emit_pkt, emit_body, use_restore, out_en;

  tbr_value_calc #(.DST_BIT(DST_BIT), .SRC_BIT(SRC_BIT)) u_value (
    .dst_tile   (cfg_dst),
    .src_tile   (cfg_src),
    .src_present(cfg_srcp),
    .set_val    (set_val),
    .rest_val   (rest_val),
    .bracket    (bracket)
  );

  tbr_fsm #(.SPACE_W(SPACE_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .dst_tile      (dst_tile),
    .src_tile      (src_tile),
    .src_present   (src_present),
    .max_body      (max_body),
    .free_space    (free_space),
    .body_valid    (body_valid),
    .body_last     (body_last),
    .implicit_flush(implicit_flush),
    .bracket       (bracket),
    .cfg_dst       (cfg_dst),
    .cfg_src       (cfg_src),
    .cfg_srcp      (cfg_srcp),
    .idx           (idx),
    .emit_pkt      (emit_pkt),
    .emit_body     (emit_body),
    .use_restore   (use_restore),
    .busy          (busy),
    .body_open     (body_open),
    .ring_flush    (ring_flush),
    .flush_conflict(flush_conflict),
    .done          (done)
  );

  assign pkt_value = use_restore ? rest_val : set_val;

  tbr_packet_gen #(.FLUSH_OPC(FLUSH_OPC), .LOAD_OPC(LOAD_OPC), .CTRL_ADDR(CTRL_ADDR)) u_pkt (
    .idx  (idx),
    .value(pkt_value),
    .dword(pkt_dword)
  );

  assign out_en = emit_pkt || emit_body;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= out_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_data <= '0;
    else if (out_en) out_data <= emit_pkt ? pkt_dword : body_data;
  end

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> !out_valid);

  assert_flush_before_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_flush |-> !out_valid);

  assert_done_after_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !busy);
endmodule

// File: tb/tile_bracket_seq_bench.sv
module tile_bracket_seq_bench;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, src_present, body_valid, body_last, implicit_flush;
  logic [1:0]    dst_tile, src_tile;
  logic [SW-1:0] max_body, free_space;
  logic [31:0]   body_data, out_data;
  logic          busy, body_open, out_valid, ring_flush, flush_conflict, done;

  always #2.5 clk = ~clk;

  tile_bracket_seq #(.SPACE_W(SW)) u_tile_bracket_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_tile(dst_tile), .src_tile(src_tile),
    .src_present(src_present), .max_body(max_body), .free_space(free_space),
    .body_valid(body_valid), .body_data(body_data), .body_last(body_last),
    .implicit_flush(implicit_flush), .busy(busy), .body_open(body_open),
    .out_valid(out_valid), .out_data(out_data), .ring_flush(ring_flush),
    .flush_conflict(flush_conflict), .done(done)
  );

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string       exp_tag[$];
  int grp_out, grp_flush, grp_conf, grp_done, flush_late;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as dwords leave the block.
  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      if (ring_flush) begin
        grp_flush++;
        if (grp_out > 0) flush_late++;
      end
      if (flush_conflict) grp_conf++;
      if (done) grp_done++;
      if (out_valid) begin
        grp_out++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected dword", out_data, 0);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = exp_tag.pop_front();
          check(out_data === e, t, out_data, e);
        end
      end
    end
  end

  function automatic logic [31:0] reg_value(input logic [1:0] dt, input logic [1:0] st, input bit sp);
    logic [15:0] d = '0;
    if (dt == 2'b10) d[0] = 1'b1;
    if (sp && st == 2'b10) d[1] = 1'b1;
    return {d, d};
  endfunction

  task automatic push_pkt(input logic [31:0] v, input string t);
    exp_q.push_back(32'h1300_0002); exp_tag.push_back(t);
    for (int k = 0; k < 3; k++) begin exp_q.push_back(32'h0); exp_tag.push_back(t); end
    exp_q.push_back(32'h1100_0001); exp_tag.push_back(t);
    exp_q.push_back(32'h0002_2200); exp_tag.push_back(t);
    exp_q.push_back(v);             exp_tag.push_back(t);
  endtask

  // Driver: runs one group and checks its side pulses.
  task automatic run_group(input logic [1:0] dt, input logic [1:0] st, input bit sp,
                           input int mx, input int fr, input int n, input int conf_at,
                           input bit exp_flush, input string req);
    logic [31:0] v = reg_value(dt, st, sp);
    bit br = (v != 0);
    grp_out = 0; grp_flush = 0; grp_conf = 0; grp_done = 0; flush_late = 0;
    if (br) push_pkt(v, {req, " R4 prologue"});
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(32'hB000_0000 + 32'(i) + 32'(n << 8)); exp_tag.push_back({req, " R6 body"});
    end
    if (br) push_pkt({v[31:16], 16'h0}, {req, " R7 epilogue"});
    @(negedge clk);
    start = 1'b1; dst_tile = dt; src_tile = st; src_present = sp;
    max_body = SW'(mx); free_space = SW'(fr);
    @(negedge clk);
    start = 1'b0;
    while (!body_open) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      body_valid = 1'b1; body_data = 32'hB000_0000 + 32'(i) + 32'(n << 8);
      body_last = (i == n - 1); implicit_flush = (i == conf_at);
      @(negedge clk);
    end
    body_valid = 1'b0; body_last = 1'b0; implicit_flush = 1'b0;
    while (grp_done == 0) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, {req, " R9 stream complete at done"}, exp_q.size(), 0);
    check(!busy, {req, " R9 idle after done"}, busy, 0);
    check(grp_done == 1, {req, " R9 single done"}, grp_done, 1);
    check(grp_flush == (exp_flush ? 1 : 0), {req, " R5 flush count"}, grp_flush, exp_flush);
    check(flush_late == 0, {req, " R5 flush before output"}, flush_late, 0);
    check(grp_conf == ((br && conf_at >= 0) ? 1 : 0), {req, " R8 conflict count"},
          grp_conf, (br && conf_at >= 0));
    exp_q.delete(); exp_tag.delete();
  endtask

  initial begin
    rst_n = 1'b0; start = 0; dst_tile = 0; src_tile = 0; src_present = 0;
    max_body = 0; free_space = 0; body_valid = 0; body_data = 0; body_last = 0;
    implicit_flush = 0;
    repeat (3) @(negedge clk);
    check({busy, body_open, out_valid, ring_flush, flush_conflict, done} == 6'b0,
          "R1 reset outputs", {busy, body_open, out_valid, ring_flush, flush_conflict, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, out_valid, done} == 3'b0, "R1 after release", {busy, out_valid, done}, 0);

    // R11: body_valid while idle produces nothing (monitor flags any dword).
    body_valid = 1'b1; body_data = 32'hDEAD_BEEF; body_last = 1'b1;
    repeat (4) @(negedge clk);
    body_valid = 1'b0; body_last = 1'b0;
    repeat (2) @(negedge clk);
    check(!out_valid && !busy, "R11 idle body ignored", out_valid, 0);

    run_group(2'b00, 2'b00, 1'b1, 8, 1, 3, -1, 1'b0, "R3 linear/linear");
    run_group(2'b01, 2'b01, 1'b1, 8, 2, 2, -1, 1'b0, "R3 X/X");
    run_group(2'b10, 2'b00, 1'b0, 8, 500, 2, -1, 1'b0, "R2 dst Y");
    run_group(2'b10, 2'b10, 1'b1, 8, 10, 4, -1, 1'b1, "R2 both Y short space");
    run_group(2'b01, 2'b10, 1'b0, 8, 0, 2, -1, 1'b0, "R10 src Y absent");
    run_group(2'b00, 2'b10, 1'b1, 20, 34, 1, -1, 1'b0, "R5 space exact");
    run_group(2'b00, 2'b10, 1'b1, 20, 33, 1, -1, 1'b1, "R5 space one short");
    run_group(2'b10, 2'b00, 1'b0, 4, 100, 5, 2, 1'b0, "R8 conflict in bracket");
    run_group(2'b00, 2'b00, 1'b0, 4, 100, 3, 1, 1'b0, "R8 no bracket no conflict");
    run_group(2'b10, 2'b10, 1'b1, 0, 13, 1, 0, 1'b1, "R6 single body dword");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule